// File: doc/BRIEF.md
# Per-Source Trigger Interrupt Aggregator

This block collects thirty-two independent interrupt lines and folds them into one request for a parent interrupt controller. Each line can be set to one of four trigger styles: active-high level, active-low level, rising edge or falling edge. Every raw line passes through a synchroniser before its trigger is evaluated. The result lands in a status word. For a level-mode line, that bit tracks the line. For an edge-mode line, the bit latches the event until software acknowledges it.

Software reaches the block through a plain word-addressed register port. It can read status, program the per-line mask, pick polarity and trigger style, acknowledge latched events with a write-ones-to-clear word, and raise events itself through a write-ones-to-set word. The request to the parent is the registered OR of every status bit that is also unmasked. Choosing among pending lines and dispatching them is left to software.

Top module: `trig_intc`

## Requirements
- R1: After reset the enable word and the edge-select word are 0, the polarity word is all ones, status is 0 and `irq_out` is 0.
- R2: Registers sit at byte offsets 0x00 status, 0x04 enable, 0x08 set, 0x0C clear, 0x10 polarity and 0x14 edge-select. Enable, polarity and edge-select read back the value last written.
- R3: A line with edge-select 0 is level-triggered. With polarity 1 its status bit equals the synchronised input. With polarity 0 its status bit equals the inverted synchronised input.
- R4: A line with edge-select 1 is edge-triggered, on a 0-to-1 transition when polarity is 1 and on a 1-to-0 transition when polarity is 0. Its status bit then stays 1 until cleared.
- R5: Writing 1 to a bit of the clear word drops that edge-mode status bit, and a 0 bit has no effect. On a level-mode line that is still active, the status bit remains 1 after the clear.
- R6: If a clear write and a new edge event for the same line fall in the same cycle, the status bit ends up 1.
- R7: Writing 1 to a bit of the set word makes that status bit 1 on the next cycle. It stays 1 on an edge-mode line, and for one cycle only on an inactive level-mode line.
- R8: Reads of the set word, the clear word and the unused offsets 0x18 and 0x1C return 0.
- R9: `irq_out` is 1 one cycle after some bit is 1 in both status and enable, and 0 otherwise. A bit with enable 0 never raises it.
- R10: A change on `src_in` reaches the status word on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N_SRC | Raw interrupt lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register being accessed |
| wr_data | input | N_SRC | Write data |
| rd_data | output | N_SRC | Read data for `addr`, combinational |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
The bench builds the block with its defaults: thirty-two lines, a five-bit address and two synchroniser stages. The five-bit address gives a three-bit word index, so the two unused slots at 0x18 and 0x1C can be read. The default depth pins the third-edge arrival that the latency test counts. Lines 0, 1, 5, 8 and 9 are taken through all four trigger styles, including a switch from level to edge mode while a level event is present. The same-cycle clear-against-edge race is placed exactly on the edge where the detected event is registered.

// File: rtl/trig_intc_pkg.sv
package trig_intc_pkg;

    // Word slots decoded from addr[ADDR_W-1:2]; the numbering fixes the map.
    typedef enum logic [2:0] {
        SLOT_STATUS   = 3'd0,
        SLOT_ENABLE   = 3'd1,
        SLOT_SET      = 3'd2,
        SLOT_CLEAR    = 3'd3,
        SLOT_POLARITY = 3'd4,
        SLOT_EDGESEL  = 3'd5
    } reg_slot_e;

    // Two-bit trigger setting of one line.
    typedef struct packed {
        logic edge_sel;   // 1: transition, 0: level
        logic act_high;   // 1: high / rising, 0: low / falling
    } trig_cfg_t;

    // Software commands reaching one status bit in a cycle.
    typedef struct packed {
        logic raise;
        logic drop;
    } sw_cmd_t;

    function automatic logic trig_hit(trig_cfg_t cfg, logic cur, logic prv);
        if (cfg.edge_sel)
            return cfg.act_high ? (cur & ~prv) : (~cur & prv);
        return cfg.act_high ? cur : ~cur;
    endfunction

    // Edge lines hold until dropped; a hit or raise beats a drop.
    function automatic logic next_status(trig_cfg_t cfg, logic hit,
                                         logic held, sw_cmd_t cmd);
        if (cfg.edge_sel)
            return hit | cmd.raise | (held & ~cmd.drop);
        return hit | cmd.raise;
    endfunction

endpackage

// File: rtl/trig_intc_sync.sv
module trig_intc_sync #(
    parameter int N_SRC  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] async_in,
    output logic [N_SRC-1:0] sync_out,
    output logic [N_SRC-1:0] prev_out
);
    localparam int LAST = STAGES - 1;

    logic [N_SRC-1:0] chain [STAGES];
    logic [N_SRC-1:0] prev_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= async_in;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= chain[LAST];
    end

    assign sync_out = chain[LAST];
    assign prev_out = prev_q;
endmodule

// File: rtl/trig_intc_regs.sv
module trig_intc_regs
    import trig_intc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_SRC-1:0]  wr_data,
    input  logic [N_SRC-1:0]  status_in,
    output logic [N_SRC-1:0]  rd_data,
    output logic [N_SRC-1:0]  enable_q,
    output logic [N_SRC-1:0]  polarity_q,
    output logic [N_SRC-1:0]  edge_q,
    output logic [N_SRC-1:0]  set_mask,
    output logic [N_SRC-1:0]  clr_mask
);
    localparam int SLOT_W = ADDR_W - 2;

    logic [SLOT_W-1:0] slot;
    assign slot = addr[ADDR_W-1:2];

    function automatic logic at_slot(logic [SLOT_W-1:0] s, reg_slot_e e);
        return s == SLOT_W'(e);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q   <= '0;
            polarity_q <= '1;
            edge_q     <= '0;
        end else if (wr_en) begin
            if (at_slot(slot, SLOT_ENABLE))   enable_q   <= wr_data;
            if (at_slot(slot, SLOT_POLARITY)) polarity_q <= wr_data;
            if (at_slot(slot, SLOT_EDGESEL))  edge_q     <= wr_data;
        end
    end

    assign set_mask = (wr_en && at_slot(slot, SLOT_SET))   ? wr_data : '0;
    assign clr_mask = (wr_en && at_slot(slot, SLOT_CLEAR)) ? wr_data : '0;

    always_comb begin
        rd_data = '0;
        if (at_slot(slot, SLOT_STATUS))   rd_data = status_in;
        if (at_slot(slot, SLOT_ENABLE))   rd_data = enable_q;
        if (at_slot(slot, SLOT_POLARITY)) rd_data = polarity_q;
        if (at_slot(slot, SLOT_EDGESEL))  rd_data = edge_q;
    end
endmodule

// File: rtl/trig_intc_status.sv
module trig_intc_status
    import trig_intc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] sync_in,
    input  logic [N_SRC-1:0] prev_in,
    input  logic [N_SRC-1:0] edge_cfg,
    input  logic [N_SRC-1:0] pol_cfg,
    input  logic [N_SRC-1:0] set_mask,
    input  logic [N_SRC-1:0] clr_mask,
    output logic [N_SRC-1:0] status
);
    logic [N_SRC-1:0] status_d;

    genvar i;
    generate
        for (i = 0; i < N_SRC; i++) begin : g_line
            trig_cfg_t cfg;
            sw_cmd_t   cmd;
            logic      hit;
            assign cfg      = '{edge_sel: edge_cfg[i], act_high: pol_cfg[i]};
            assign cmd      = '{raise: set_mask[i], drop: clr_mask[i]};
            assign hit      = trig_hit(cfg, sync_in[i], prev_in[i]);
            assign status_d[i] = next_status(cfg, hit, status[i], cmd);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= status_d;
    end
endmodule

// File: rtl/trig_intc_combine.sv
module trig_intc_combine #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] status,
    input  logic [N_SRC-1:0] enable,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(status & enable);
    end
endmodule

// File: rtl/trig_intc.sv
module trig_intc #(
    parameter int N_SRC       = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_SRC-1:0]  wr_data,
    output logic [N_SRC-1:0]  rd_data,
    output logic              irq_out
);
    logic [N_SRC-1:0] sync_lvl, prev_lvl;
    logic [N_SRC-1:0] status_q, enable_q, polarity_q, edge_q;
    logic [N_SRC-1:0] set_mask, clr_mask;

    trig_intc_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(src_in),
        .sync_out(sync_lvl), .prev_out(prev_lvl)
    );

    trig_intc_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .status_in(status_q), .rd_data(rd_data), .enable_q(enable_q),
        .polarity_q(polarity_q), .edge_q(edge_q),
        .set_mask(set_mask), .clr_mask(clr_mask)
    );

    trig_intc_status #(.N_SRC(N_SRC)) u_status (
        .clk(clk), .rst(rst), .sync_in(sync_lvl), .prev_in(prev_lvl),
        .edge_cfg(edge_q), .pol_cfg(polarity_q),
        .set_mask(set_mask), .clr_mask(clr_mask), .status(status_q)
    );

    trig_intc_combine #(.N_SRC(N_SRC)) u_combine (
        .clk(clk), .rst(rst), .status(status_q), .enable(enable_q),
        .irq(irq_out)
    );
endmodule

// File: rtl/trig_intc_chk.sv
module trig_intc_chk #(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [N_SRC-1:0]  wr_data,
    input logic [N_SRC-1:0]  rd_data,
    input logic              irq_out,
    input logic [N_SRC-1:0]  status_q,
    input logic [N_SRC-1:0]  enable_q,
    input logic [N_SRC-1:0]  polarity_q,
    input logic [N_SRC-1:0]  edge_q
);
    localparam int SLOT_W = ADDR_W - 2;

    logic [SLOT_W-1:0] slot;
    logic [N_SRC-1:0]  clr_w, set_w;
    logic              zero_slot;

    assign slot      = addr[ADDR_W-1:2];
    assign clr_w     = (wr_en && slot == SLOT_W'(3)) ? wr_data : '0;
    assign set_w     = (wr_en && slot == SLOT_W'(2)) ? wr_data : '0;
    assign zero_slot = (slot == SLOT_W'(2)) || (slot == SLOT_W'(3)) || (slot > SLOT_W'(5));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (enable_q == '0 && edge_q == '0 && polarity_q == '1
                 && status_q == '0 && !irq_out));

    // R9
    irq_follows_pending_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == |($past(status_q & enable_q))));

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(status_q & edge_q & ~clr_w)) & edge_q & ~status_q) == '0));

    // R7
    set_raise_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set_w) & ~status_q) == '0));

    // R8
    read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        zero_slot |-> (rd_data == '0));
endmodule

bind trig_intc trig_intc_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_out(irq_out), .status_q(status_q),
    .enable_q(enable_q), .polarity_q(polarity_q), .edge_q(edge_q)
);

// File: tb/test_trig_intc.sv
module test_trig_intc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_in = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    trig_intc i_trig_intc (
        .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
    );

    typedef struct packed {
        logic [31:0] src;
        logic        wr;
        logic [4:0]  waddr;
        logic [31:0] wdata;
        logic [4:0]  caddr;
        logic [31:0] exp;
        logic        eirq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{32'h0, 1'b0, 5'h00, 32'h0, 5'h10, 32'hFFFFFFFF, 1'b0, 8'd1},          // R1 polarity
        '{32'h0, 1'b0, 5'h00, 32'h0, 5'h14, 32'h0, 1'b0, 8'd1},                 // R1 edge-select
        '{32'hF0, 1'b1, 5'h04, 32'h30, 5'h00, 32'hF0, 1'b1, 8'd3},              // R3 level high
        '{32'h0, 1'b0, 5'h00, 32'h0, 5'h00, 32'h0, 1'b0, 8'd3},                 // R3 drops
        '{32'h0, 1'b1, 5'h10, 32'hFFFFFFFE, 5'h00, 32'h1, 1'b0, 8'd3},          // R3 level low
        '{32'h0, 1'b1, 5'h04, 32'h1, 5'h00, 32'h1, 1'b1, 8'd9},                 // R9 unmask
        '{32'h1, 1'b0, 5'h00, 32'h0, 5'h00, 32'h0, 1'b0, 8'd3},                 // R3 low inactive
        '{32'h1, 1'b1, 5'h14, 32'h100, 5'h14, 32'h100, 1'b0, 8'd2},             // R2 edge-select
        '{32'h101, 1'b0, 5'h00, 32'h0, 5'h00, 32'h100, 1'b0, 8'd4},             // R4 rising
        '{32'h001, 1'b0, 5'h00, 32'h0, 5'h00, 32'h100, 1'b0, 8'd4},             // R4 held
        '{32'h001, 1'b1, 5'h04, 32'h100, 5'h00, 32'h100, 1'b1, 8'd9},           // R9
        '{32'h001, 1'b1, 5'h0C, 32'h100, 5'h00, 32'h0, 1'b0, 8'd5},             // R5 clear
        '{32'h001, 1'b1, 5'h08, 32'h100, 5'h00, 32'h100, 1'b1, 8'd7},           // R7 set edge
        '{32'h001, 1'b1, 5'h0C, 32'h0, 5'h00, 32'h100, 1'b1, 8'd5},             // R5 zeros
        '{32'h001, 1'b1, 5'h10, 32'hFFFFFDFE, 5'h10, 32'hFFFFFDFE, 1'b1, 8'd2}, // R2 polarity
        '{32'h201, 1'b1, 5'h14, 32'h300, 5'h00, 32'h300, 1'b1, 8'd4},           // R4 level bit kept
        '{32'h201, 1'b1, 5'h0C, 32'h200, 5'h00, 32'h100, 1'b1, 8'd5},           // R5
        '{32'h001, 1'b0, 5'h00, 32'h0, 5'h00, 32'h300, 1'b1, 8'd4},             // R4 falling
        '{32'h001, 1'b0, 5'h00, 32'h0, 5'h08, 32'h0, 1'b1, 8'd8},               // R8 set
        '{32'h001, 1'b0, 5'h00, 32'h0, 5'h0C, 32'h0, 1'b1, 8'd8},               // R8 clear
        '{32'h001, 1'b0, 5'h00, 32'h0, 5'h18, 32'h0, 1'b1, 8'd8},               // R8 unused
        '{32'h001, 1'b0, 5'h00, 32'h0, 5'h1C, 32'h0, 1'b1, 8'd8},               // R8 unused
        '{32'h001, 1'b1, 5'h04, 32'h0, 5'h04, 32'h0, 1'b0, 8'd9},               // R9 mask all
        '{32'h001, 1'b0, 5'h00, 32'h0, 5'h00, 32'h300, 1'b0, 8'd9}              // R9 status kept
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 5'h00;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state at the ports
        addr = 5'h00; #1; check("R1 status", rd_data, 32'h0);
        addr = 5'h04; #1; check("R1 enable", rd_data, 32'h0);
        check("R1 irq", {31'h0, irq_out}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            src_in = VEC[v].src; wr_en = VEC[v].wr;
            addr = VEC[v].waddr; wr_data = VEC[v].wdata;
            @(negedge clk);
            wr_en = 1'b0;
            repeat (3) @(negedge clk);
            addr = VEC[v].caddr;
            #1;
            check($sformatf("R%0d vec %0d data", VEC[v].req, v), rd_data, VEC[v].exp);
            check($sformatf("R%0d vec %0d irq", VEC[v].req, v), {31'h0, irq_out}, {31'h0, VEC[v].eirq});
        end

        // R5 clear everything, then R6 clear coinciding with a rising edge on line 8
        write_reg(5'h0C, 32'hFFFFFFFF);
        check("R5 clear all", rd_data, 32'h0);
        @(negedge clk); src_in = 32'h101;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = 5'h0C; wr_data = 32'h100;
        @(negedge clk); wr_en = 1'b0; addr = 5'h00; #1;
        check("R6 edge beats clear", rd_data & 32'h100, 32'h100);
        write_reg(5'h0C, 32'h100);
        check("R5 later clear", rd_data & 32'h100, 32'h0);

        // R5 level-low line 0 active: clear has no lasting effect
        @(negedge clk); src_in = 32'h100;
        repeat (4) @(negedge clk);
        #1; check("R3 level low active", rd_data, 32'h1);
        write_reg(5'h0C, 32'h1);
        check("R5 level clear ignored", rd_data, 32'h1);

        // R7 set on inactive level line 5: one cycle only
        write_reg(5'h08, 32'h20);
        check("R7 level set pulse", rd_data, 32'h21);
        @(negedge clk); #1;
        check("R7 level set ends", rd_data, 32'h1);

        // R9 output registered one cycle behind enable
        write_reg(5'h04, 32'h1);
        check("R9 irq not yet", {31'h0, irq_out}, 32'h0);
        @(negedge clk); #1;
        check("R9 irq raised", {31'h0, irq_out}, 32'h1);

        // R10 line 1 level-high arrives on the third edge
        src_in = 32'h102;
        @(negedge clk); #1; check("R10 edge 1", rd_data & 32'h2, 32'h0);
        @(negedge clk); #1; check("R10 edge 2", rd_data & 32'h2, 32'h0);
        @(negedge clk); #1; check("R10 edge 3", rd_data & 32'h2, 32'h2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule